// File: doc/BRIEF.md
# Count/Compare Cycle Timer

This block is a free-running 32-bit cycle counter paired with a 32-bit comparison register. Each enabled tick advances the counter by one. When the counter steps onto the comparison value, the block enters a pending state and drives exactly one of eight interrupt lines, picked by a 3-bit routing input. The pending state lasts until software writes the comparison register, however far the counter runs past the match in the meantime.

Software reaches both registers through a one-cycle write strobe with a register select. Both values are always visible on output ports. A freeze input stops the counter, and a frozen counter cannot produce a match. A feature input enables a timer status bit. The interrupt line itself rises and falls whether or not that feature input is set.

Control is a two-state machine. In ST_IDLE nothing is pending. The transition T_MATCH moves it to ST_PEND when the counter reaches the comparison value. The transition T_ACK returns it to ST_IDLE when the comparison register is written. In every other case the machine stays in its current state (T_HOLD).

Top module: `cyc_timer`

## Requirements
- R1: When `tick_i` is 1 and `freeze_i` is 0, `count_o` increases by one (modulo 2^32) at the clock edge. When `tick_i` is 0, `count_o` keeps its value.
- R2: While `freeze_i` is 1, ticks leave `count_o` unchanged and no match can occur.
- R3: On the edge where an advancing count becomes equal to `compare_o`, the block becomes pending. This includes the wrap from 0xFFFFFFFF to 0.
- R4: A write with `wr_sel_i` = 1 loads `compare_o` from `wr_data_i` and clears the pending state. All `irq_o` bits are 0 after that edge.
- R5: While pending, `irq_o` has only bit `route_i` set. When not pending, `irq_o` is all zeros.
- R6: A write with `wr_sel_i` = 0 loads `count_o` from `wr_data_i`, whether or not the count is frozen. A count write in the same cycle as a tick takes precedence over the increment, and no match is flagged in that cycle.
- R7: `status_o` equals the pending state when `rev2_i` is 1 and is 0 when `rev2_i` is 0. `irq_o` does not depend on `rev2_i`.
- R8: After reset, `count_o` is 1, `compare_o` is 0, and nothing is pending.
- R9: Once pending, the block stays pending through further ticks until `compare_o` is written.
- R10: If a compare write and a match fall in the same cycle, the write wins and the block is not pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer tick enable |
| freeze_i | input | 1 | Stops the counter when 1 |
| rev2_i | input | 1 | Enables the timer status bit |
| route_i | input | 3 | Selects the interrupt line |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects count, 1 selects compare |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current count value |
| compare_o | output | 32 | Current compare value |
| status_o | output | 1 | Timer status bit |
| irq_o | output | 8 | Interrupt lines |

## Verification
The match-and-clear cycle is swept over all eight routing values, each with the status feature on and off. The distance from count to compare grows with the routing value, so an off-by-one in match timing, a wrong decoded line, or an ungated status bit each give a different wrong result. Separate patterns cover the 0xFFFFFFFF-to-0 wrap, ticking with the counter frozen, and count writes racing a tick. Two further patterns cover a compare write landing on the matching tick and ticks running past the match. These show that only a compare write releases the interrupt.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/cyc_timer_count.sv
// Count and compare registers plus match detection on an advancing tick.
module cyc_timer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             freeze_i,
    input  logic             cnt_wr_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] compare_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             adv;

    assign adv     = tick_i & ~freeze_i;
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(1);
            cmp_q <= '0;
        end else begin
            if (cnt_wr_i) begin
                cnt_q <= wr_data_i;
            end else if (adv) begin
                cnt_q <= cnt_inc;
            end
            if (cmp_wr_i) begin
                cmp_q <= wr_data_i;
            end
        end
    end

    assign match_o   = adv & ~cnt_wr_i & (cnt_inc == cmp_q);
    assign count_o   = cnt_q;
    assign compare_o = cmp_q;
endmodule

// File: rtl/cyc_timer_fsm.sv
// Pending-interrupt state machine: ST_IDLE <-> ST_PEND.
module cyc_timer_fsm
    import cyc_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic cmp_wr_i,
    input  logic rev2_i,
    output logic pend_o,
    output logic status_o
);
    tmr_state_e state_q;
    tmr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (match_i && !cmp_wr_i) state_d = ST_PEND;   // T_MATCH
            ST_PEND: if (cmp_wr_i)             state_d = ST_IDLE;   // T_ACK
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend_o   = (state_q == ST_PEND);
        status_o = pend_o & rev2_i;
    end
endmodule

// File: rtl/cyc_timer_route.sv
// Decodes the routing field onto one of LINE_N interrupt lines.
module cyc_timer_route #(
    parameter int LINE_N = 8,
    localparam int SEL_W = $clog2(LINE_N)
) (
    input  logic             active_i,
    input  logic [SEL_W-1:0] route_i,
    output logic [LINE_N-1:0] irq_o
);
    for (genvar i = 0; i < LINE_N; i++) begin : g_line
        assign irq_o[i] = active_i && (route_i == SEL_W'(i));
    end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
    parameter int CNT_W  = 32,
    parameter int LINE_N = 8,
    localparam int SEL_W = $clog2(LINE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              freeze_i,
    input  logic              rev2_i,
    input  logic [SEL_W-1:0]  route_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  compare_o,
    output logic              status_o,
    output logic [LINE_N-1:0] irq_o
);
    logic cnt_wr;
    logic cmp_wr;
    logic match;
    logic pend;

    assign cnt_wr = wr_en_i & ~wr_sel_i;
    assign cmp_wr = wr_en_i &  wr_sel_i;

    cyc_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .freeze_i  (freeze_i),
        .cnt_wr_i  (cnt_wr),
        .cmp_wr_i  (cmp_wr),
        .wr_data_i (wr_data_i),
        .count_o   (count_o),
        .compare_o (compare_o),
        .match_o   (match)
    );

    cyc_timer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .cmp_wr_i (cmp_wr),
        .rev2_i   (rev2_i),
        .pend_o   (pend),
        .status_o (status_o)
    );

    cyc_timer_route #(.LINE_N(LINE_N)) u_route (
        .active_i (pend),
        .route_i  (route_i),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int LINE_N = 8,
    localparam int SEL_W = $clog2(LINE_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              freeze_i,
    input logic              rev2_i,
    input logic [SEL_W-1:0]  route_i,
    input logic              wr_en_i,
    input logic              wr_sel_i,
    input logic [CNT_W-1:0]  wr_data_i,
    input logic [CNT_W-1:0]  count_o,
    input logic [CNT_W-1:0]  compare_o,
    input logic              status_o,
    input logic [LINE_N-1:0] irq_o
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i && !wr_en_i) |=> (count_o == $past(count_o) + CNT_W'(1))); // R1
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !(wr_en_i && !wr_sel_i)) |=> $stable(count_o)); // R2
    AST_MATCH_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i && !wr_en_i && (count_o + CNT_W'(1) == compare_o)) |=> (irq_o != '0)); // R3
    AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> (irq_o == '0 && !status_o)); // R4
    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o)); // R5
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (count_o == $past(wr_data_i))); // R6
    AST_STATUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !rev2_i |-> !status_o); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o != '0) && !wr_en_i) |=> (irq_o != '0)); // R9
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W), .LINE_N(LINE_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
    .rev2_i(rev2_i), .route_i(route_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .compare_o(compare_o),
    .status_o(status_o), .irq_o(irq_o)
);

// File: tb/cyc_timer_bench.sv
module cyc_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        freeze_i = 1'b0;
    logic        rev2_i = 1'b0;
    logic [2:0]  route_i = '0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] count_o;
    logic [31:0] compare_o;
    logic        status_o;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cyc_timer u_cyc_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
        .rev2_i(rev2_i), .route_i(route_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .count_o(count_o), .compare_o(compare_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] base;
        repeat (3) step();
        rst_n = 1'b1;
        // R8 reset state
        check(count_o == 32'd1, "R8 count", count_o, 32'd1);
        check(compare_o == 32'd0, "R8 compare", compare_o, 32'd0);
        check(irq_o == 8'd0, "R8 irq", {24'd0, irq_o}, 32'd0);

        // R1 no tick holds
        step();
        check(count_o == 32'd1, "R1 hold", count_o, 32'd1);

        // Sweep routing and feature bit
        for (int r = 0; r < 8; r++) begin
            for (int v = 0; v < 2; v++) begin
                route_i = 3'(r); rev2_i = v[0];
                base = 32'(r * 1000 + v * 77 + 5);
                wr(1'b0, base);
                wr(1'b1, base + 32'(r + 2));
                for (int k = 0; k < r + 1; k++) begin
                    tick();
                    check(count_o == base + 32'(k + 1), "R1 step", count_o, base + 32'(k + 1));
                    check(irq_o == 8'd0, "R3 early", {24'd0, irq_o}, 32'd0);
                end
                tick();
                check(irq_o == (8'd1 << r), "R5 line", {24'd0, irq_o}, {24'd0, 8'd1 << r});
                check(status_o == v[0], "R7 status", {31'd0, status_o}, {31'd0, v[0]});
                tick(); tick();
                check(irq_o == (8'd1 << r), "R9 sticky", {24'd0, irq_o}, {24'd0, 8'd1 << r});
                wr(1'b1, base);
                check(irq_o == 8'd0 && !status_o, "R4 clear", {23'd0, status_o, irq_o}, 32'd0);
            end
        end

        // R3 wrap
        route_i = 3'd2; rev2_i = 1'b1;
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'd0);
        tick();
        check(count_o == 32'd0, "R3 wrap count", count_o, 32'd0);
        check(irq_o == 8'd4, "R3 wrap irq", {24'd0, irq_o}, 32'd4);
        wr(1'b1, 32'd50);

        // R2 freeze
        wr(1'b0, 32'd49);
        freeze_i = 1'b1;
        repeat (4) tick();
        check(count_o == 32'd49, "R2 frozen", count_o, 32'd49);
        check(irq_o == 8'd0, "R2 no match", {24'd0, irq_o}, 32'd0);
        // R6 load while frozen
        wr(1'b0, 32'd1234);
        check(count_o == 32'd1234, "R6 frozen load", count_o, 32'd1234);
        freeze_i = 1'b0;

        // R6 load beats tick, no match
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'd49; tick_i = 1'b1;
        step();
        wr_en_i = 1'b0; tick_i = 1'b0;
        check(count_o == 32'd49, "R6 load wins", count_o, 32'd49);
        check(irq_o == 8'd0, "R6 no match", {24'd0, irq_o}, 32'd0);

        // R10 compare write on matching tick
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 32'd50; tick_i = 1'b1;
        step();
        wr_en_i = 1'b0; tick_i = 1'b0;
        check(count_o == 32'd50, "R10 count", count_o, 32'd50);
        check(irq_o == 8'd0 && !status_o, "R10 write wins", {23'd0, status_o, irq_o}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule